// File: doc/BRIEF.md
# Four-Channel Countdown Timer Bank

This block holds four independent countdown timers that sit beside an interrupt controller. Software configures them through a small word-addressed register bus. A typical use is to arm one channel as a wake-up source before the system goes to sleep. Every channel counts down at a rate set by one shared prescaler. When a channel runs out, it reloads its base value, keeps counting, and raises a one-clock interrupt request. The request comes with that channel's vector, priority and target-processor mask, so the arbitration logic downstream can route it.

Each channel has four registers: a live count that software can only read, a base count whose top bit stops the channel, a routing word with a mask bit, a priority and a vector, and a one-hot destination. To start a channel, software first writes the base value with the stop bit set, which loads the value into the live count. It then writes the same value with the stop bit clear, which releases the counter. One control word is shared by all channels and chooses a prescale of 8 or 64 system clocks per count step.

Reads are combinational on the address alone. `bus_sel` together with `bus_wr` qualifies a write, and the write takes effect at the next rising clock edge.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every channel reads: live count 0, base register 0x8000_0000 (stopped, base 0), routing word 0x8000_0000 (masked, priority 0, vector 0), destination 0. The control word reads 0 and no `irq_req` bit is high.
- R2: Channel n occupies byte offsets n*0x40 + {0x00 live count, 0x10 base, 0x20 routing, 0x30 destination}. The control word is at 0x200. Any other address reads 0, and a write to it changes no register.
- R3: While bit 31 of a channel's base register is set, its live count holds its value.
- R4: A base write with bit 31 set loads bits 30:0 into the live count. A base write with bit 31 clear, made while the channel is stopped, also loads bits 30:0 and releases the channel. From then on the live count drops by one on each prescaler step.
- R5: A running channel whose live count is 1 or 0 at a prescaler step expires: it reloads the stored base value. The expiry period is therefore max(base,1) steps. A base write with bit 31 clear, made while the channel is running, changes only the value used at the next reload.
- R6: Control bits 9:8 equal to 2'b11 select one step per 64 clocks. Any other value selects one step per 8 clocks. The control word reads back as bits 9:8 only.
- R7: While bit 31 of the routing word is set, an expiry produces no request and is not kept for later. Clearing the bit lets later expiries through.
- R8: Each unmasked expiry drives `irq_req[n]` high for exactly one clock. `irq_vec` carries routing bits 15:0 and `irq_prio` carries bits 19:16. Routing bits 30:20 read as 0, so software can rewrite the priority alone without changing the vector or the mask.
- R9: Destination bits 3:0 form a one-hot processor select. They read back with the other bits as 0, and appear on `irq_dest`.
- R10: A write to the live-count offset has no effect.
- R11: Channels do not affect one another: each keeps its own period and its own requests while the others run or stay stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write enable, qualified by `bus_sel` |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| irq_req | output | 4 | Per-channel one-clock expiry request |
| irq_vec | output | 64 | Per-channel vector, 16 bits each, channel 0 lowest |
| irq_prio | output | 16 | Per-channel priority, 4 bits each |
| irq_dest | output | 16 | Per-channel one-hot processor select, 4 bits each |

## Verification
The live count is readable, so a wrong count or a wrong stop flag shows on `bus_rdata` at the very next read. A window of 80 clocks at the fast prescale must show a drop of exactly ten.

A prescaler or reload fault shows as a wrong spacing between two `irq_req` pulses. Such a fault therefore appears within one period, at most 64 times the base value in clocks.

A routing-word fault shows on the static `irq_vec`, `irq_prio` and `irq_dest` outputs at once. A failed mask shows as a request that appears inside a window where none may occur.

// File: rtl/tmr_bank_pkg.sv
// Shared constants and types for the countdown timer bank.
// Assumes a 32-bit data bus and fixed bit positions inside each register word.
package tmr_bank_pkg;
    localparam int DATA_W    = 32;
    localparam int STOP_BIT  = 31;   // stop flag in the base register
    localparam int MASK_BIT  = 31;   // request mask in the routing word
    localparam int PRIO_LSB  = 16;
    localparam int PRIO_W    = 4;
    localparam int VEC_W     = 16;
    localparam int REG_LSB   = 4;    // 16-byte register spacing
    localparam int CH_LSB    = 6;    // 64-byte channel stride
    localparam int ROUTE_PAD = DATA_W - 1 - PRIO_W - VEC_W;

    typedef enum logic [1:0] {
        REG_LIVE  = 2'd0,
        REG_BASE  = 2'd1,
        REG_ROUTE = 2'd2,
        REG_DEST  = 2'd3
    } tmr_reg_e;
endpackage

// File: rtl/tmr_bus_decode.sv
// Address decoder for the timer bank.
// Splits a byte address into a channel index and a register select, and
// flags the shared control word. It turns a write into at most one strobe.
// Assumes word-aligned register offsets; any other address decodes to nothing.
module tmr_bus_decode
    import tmr_bank_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 10,
    parameter int CTRL_ADDR = 'h200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic                  ch_hit,
    output logic [$clog2(NUM_CH > 1 ? NUM_CH : 2)-1:0] ch_idx,
    output tmr_reg_e              reg_sel,
    output logic                  ctrl_hit,
    output logic [NUM_CH-1:0]     ch_wr,
    output logic                  ctrl_wr
);
    localparam int IDX_W   = $clog2(NUM_CH > 1 ? NUM_CH : 2);
    localparam int UPPER_W = ADDR_W - CH_LSB;

    logic wr_cycle;

    // Classify the address: channel register, control word, or unmapped.
    always_comb begin
        ch_hit   = (bus_addr[ADDR_W-1:CH_LSB] < UPPER_W'(NUM_CH)) &&
                   (bus_addr[REG_LSB-1:0] == '0);
        ch_idx   = bus_addr[CH_LSB +: IDX_W];
        reg_sel  = tmr_reg_e'(bus_addr[CH_LSB-1:REG_LSB]);
        ctrl_hit = (bus_addr == ADDR_W'(CTRL_ADDR));
        wr_cycle = bus_sel && bus_wr;
        ctrl_wr  = wr_cycle && ctrl_hit;
    end

    // One write strobe per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        assign ch_wr[g] = wr_cycle && ch_hit && (ch_idx == IDX_W'(g));
    end

    // A write reaches at most one target.
    assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_wr, ctrl_wr}));
endmodule

// File: rtl/tmr_prescaler.sv
// Shared step generator for the timer bank.
// A free-running counter gives a one-clock step every FAST_DIV clocks, or
// every SLOW_DIV clocks while slow_sel is high. A change of rate takes
// effect on the running count and needs no restart.
// Assumes FAST_DIV >= 2 and SLOW_DIV >= FAST_DIV.
module tmr_prescaler #(
    parameter int FAST_DIV = 8,
    parameter int SLOW_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_sel,
    output logic tick
);
    localparam int PW = $clog2(SLOW_DIV);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] limit;

    // Choose the terminal value and flag a step when it is reached.
    always_comb begin
        limit = slow_sel ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
        tick  = (cnt_q >= limit);
    end

    // Advance the divider, wrapping to zero on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + PW'(1);
    end

    // Steps never fall on two clocks in a row.
    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
// One countdown channel: base register with stop flag, live counter,
// routing word and destination mask. On a prescaler step it counts down;
// at 1 or 0 it reloads the base and, if unmasked, pulses its request.
// Assumes CNT_W <= 31, so the stop flag sits above the count field.
module tmr_channel
    import tmr_bank_pkg::*;
#(
    parameter int CNT_W   = 31,
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_en,
    input  tmr_reg_e           reg_sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [PRIO_W-1:0]  irq_prio,
    output logic [NUM_CPU-1:0] irq_dest
);
    logic [CNT_W-1:0]   base_q, live_q;
    logic               stop_q, mask_q, irq_q;
    logic [PRIO_W-1:0]  prio_q;
    logic [VEC_W-1:0]   vec_q;
    logic [NUM_CPU-1:0] dest_q;
    logic               wr_base, wr_route, wr_dest, load_now, at_end, expire;

    // Decode the write target and the load and expiry conditions.
    always_comb begin
        wr_base  = wr_en && (reg_sel == REG_BASE);
        wr_route = wr_en && (reg_sel == REG_ROUTE);
        wr_dest  = wr_en && (reg_sel == REG_DEST);
        load_now = wr_base && (wdata[STOP_BIT] || stop_q);
        at_end   = (live_q <= CNT_W'(1));
        expire   = tick && !stop_q && !load_now && at_end;
    end

    // Base value and stop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            stop_q <= 1'b1;
        end else if (wr_base) begin
            base_q <= wdata[CNT_W-1:0];
            stop_q <= wdata[STOP_BIT];
        end
    end

    // Live counter: a load wins, otherwise count or reload on a step.
    always_ff @(posedge clk) begin
        if (!rst_n)                live_q <= '0;
        else if (load_now)         live_q <= wdata[CNT_W-1:0];
        else if (tick && !stop_q)  live_q <= at_end ? base_q : live_q - CNT_W'(1);
    end

    // Routing word and destination mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            prio_q <= '0;
            vec_q  <= '0;
            dest_q <= '0;
        end else begin
            if (wr_route) begin
                mask_q <= wdata[MASK_BIT];
                prio_q <= wdata[PRIO_LSB +: PRIO_W];
                vec_q  <= wdata[VEC_W-1:0];
            end
            if (wr_dest) dest_q <= wdata[NUM_CPU-1:0];
        end
    end

    // One-clock request on an unmasked expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= expire && !mask_q;
    end

    // Register read-back for the selected offset.
    always_comb begin
        case (reg_sel)
            REG_LIVE:  rdata = DATA_W'(live_q);
            REG_BASE:  rdata = {stop_q, (DATA_W-1)'(base_q)};
            REG_ROUTE: rdata = {mask_q, {ROUTE_PAD{1'b0}}, prio_q, vec_q};
            default:   rdata = DATA_W'(dest_q);
        endcase
    end

    assign irq_req  = irq_q;
    assign irq_vec  = vec_q;
    assign irq_prio = prio_q;
    assign irq_dest = dest_q;

    // A stopped channel with no base write keeps its count.
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !wr_base) |=> $stable(live_q));
    // Count drops by one per step while running and not at the end.
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stop_q && !wr_base && !at_end) |=> (live_q == $past(live_q) - CNT_W'(1)));
    // Expiry reloads the stored base.
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stop_q && !wr_base && at_end) |=> (live_q == $past(base_q)));
    // A request implies the mask was clear.
    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(!mask_q));
    // Requests last one clock.
    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // A write to the live offset leaves a stopped count alone.
    assert_live_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == REG_LIVE && stop_q) |=> $stable(live_q));
endmodule

// File: rtl/tmr_bank.sv
// Top of the countdown timer bank: decoder, shared prescaler, the control
// word and a generated array of channels, plus the read-back mux.
// Assumes reads are combinational on the address and writes take effect
// at the next rising edge.
module tmr_bank
    import tmr_bank_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_CPU   = 4,
    parameter int CNT_W     = 31,
    parameter int FAST_DIV  = 8,
    parameter int SLOW_DIV  = 64,
    parameter int ADDR_W    = 10,
    parameter int CTRL_ADDR = 'h200
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    output logic [NUM_CH-1:0]           irq_req,
    output logic [NUM_CH*16-1:0]        irq_vec,
    output logic [NUM_CH*4-1:0]         irq_prio,
    output logic [NUM_CH*NUM_CPU-1:0]   irq_dest
);
    localparam int IDX_W   = $clog2(NUM_CH > 1 ? NUM_CH : 2);
    localparam int DIV_LSB = 8;

    logic              ch_hit, ctrl_hit, ctrl_wr, tick, slow_sel;
    logic [IDX_W-1:0]  ch_idx;
    tmr_reg_e          reg_sel;
    logic [NUM_CH-1:0] ch_wr;
    logic [1:0]        div_q;
    logic [DATA_W-1:0] ch_rdata [NUM_CH];

    tmr_bus_decode #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .ch_hit(ch_hit), .ch_idx(ch_idx),
        .reg_sel(reg_sel), .ctrl_hit(ctrl_hit), .ch_wr(ch_wr), .ctrl_wr(ctrl_wr)
    );

    // Shared control word: prescale select field.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= 2'b00;
        else if (ctrl_wr) div_q <= bus_wdata[DIV_LSB +: 2];
    end

    assign slow_sel = &div_q;

    tmr_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .slow_sel(slow_sel), .tick(tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W), .NUM_CPU(NUM_CPU)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(ch_wr[g]),
            .reg_sel(reg_sel), .wdata(bus_wdata), .rdata(ch_rdata[g]),
            .irq_req(irq_req[g]),
            .irq_vec(irq_vec[g*VEC_W +: VEC_W]),
            .irq_prio(irq_prio[g*PRIO_W +: PRIO_W]),
            .irq_dest(irq_dest[g*NUM_CPU +: NUM_CPU])
        );
    end

    // Read-back mux: control word, channel register, or zero.
    always_comb begin
        if (ctrl_hit)    bus_rdata = DATA_W'({div_q, {DIV_LSB{1'b0}}});
        else if (ch_hit) bus_rdata = ch_rdata[ch_idx];
        else             bus_rdata = '0;
    end

    // Unmapped writes leave the control word alone.
    assert_ctrl_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(div_q));
endmodule

// File: tb/tmr_bank_test.sv
module tmr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_req;
    logic [63:0] irq_vec;
    logic [15:0] irq_prio;
    logic [15:0] irq_dest;
    int n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    tmr_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_prio(irq_prio), .irq_dest(irq_dest)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [9:0] ra(input int ch, input int ofs);
        return 10'(ch * 'h40 + ofs);
    endfunction

    // Returns negedges waited until a request is seen, or -1 on timeout.
    task automatic wait_irq(input int ch, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (irq_req[ch]) return;
        end
        n = -1;
    endtask

    task automatic count_irq(input int ch, input int cycles, output int cnt);
        cnt = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (irq_req[ch]) cnt++;
        end
    endtask

    task automatic start_ch(input int ch, input int base);
        bus_write(ra(ch, 'h10), 32'h8000_0000 | 32'(base));
        bus_write(ra(ch, 'h10), 32'(base));
    endtask

    task automatic stop_ch(input int ch);
        bus_write(ra(ch, 'h10), 32'h8000_0000);
        bus_write(ra(ch, 'h20), 32'h8000_0000);
    endtask

    task automatic run_all();
        logic [31:0] rd, c0;
        int n, cnt, cnt2, div, eff;
        // R1 reset state
        for (int ch = 0; ch < 4; ch++) begin
            bus_read(ra(ch, 'h00), rd); chk("R1 live count", rd, 32'h0);
            bus_read(ra(ch, 'h10), rd); chk("R1 base", rd, 32'h8000_0000);
            bus_read(ra(ch, 'h20), rd); chk("R1 routing", rd, 32'h8000_0000);
            bus_read(ra(ch, 'h30), rd); chk("R1 destination", rd, 32'h0);
        end
        bus_read(10'h200, rd); chk("R1 control", rd, 32'h0);
        chk("R1 no request", 32'(irq_req), 32'h0);

        // R6 control readback
        bus_write(10'h200, 32'hFFFF_FFFF);
        bus_read(10'h200, rd); chk("R6 control readback", rd, 32'h300);
        bus_write(10'h200, 32'h0);

        // R2 unmapped addresses
        bus_write(10'h104, 32'hFFFF_FFFF);
        bus_write(10'h014, 32'hFFFF_FFFF);
        bus_read(10'h104, rd); chk("R2 unmapped read", rd, 32'h0);
        bus_read(10'h014, rd); chk("R2 misaligned read", rd, 32'h0);
        bus_read(10'h200, rd); chk("R2 control untouched", rd, 32'h0);
        bus_read(ra(0, 'h10), rd); chk("R2 base untouched", rd, 32'h8000_0000);
        bus_read(ra(0, 'h20), rd); chk("R2 routing untouched", rd, 32'h8000_0000);

        // R8 routing fields and priority-only rewrite
        bus_write(ra(1, 'h20), 32'hFFFF_FFFF);
        bus_read(ra(1, 'h20), rd); chk("R8 unused routing bits", rd, 32'h800F_FFFF);
        bus_write(ra(1, 'h20), 32'h000A_1234);
        bus_read(ra(1, 'h20), rd); chk("R8 routing readback", rd, 32'h000A_1234);
        bus_write(ra(1, 'h20), (rd & ~32'h000F_0000) | 32'h0003_0000);
        bus_read(ra(1, 'h20), rd); chk("R8 priority rewrite", rd, 32'h0003_1234);
        chk("R8 vector output", 32'(irq_vec[16 +: 16]), 32'h1234);
        chk("R8 priority output", 32'(irq_prio[4 +: 4]), 32'h3);
        bus_write(ra(1, 'h20), 32'h8000_0000);

        // R9 destination
        for (int ch = 0; ch < 4; ch++) begin
            bus_write(ra(ch, 'h30), 32'hFFFF_FFF0 | 32'(1 << ch));
            bus_read(ra(ch, 'h30), rd); chk("R9 destination readback", rd, 32'(1 << ch));
        end
        chk("R9 destination outputs", 32'(irq_dest), 32'h8421);

        // R10 live count is read-only
        bus_write(ra(2, 'h10), 32'h8000_0777);
        bus_write(ra(2, 'h00), 32'h0000_0123);
        bus_read(ra(2, 'h00), rd); chk("R10 write to live ignored", rd, 32'h777);

        // R3 stopped channel holds
        wcyc(200);
        bus_read(ra(2, 'h00), rd); chk("R3 hold while stopped", rd, 32'h777);

        // R4 start sequence and step rate (10 steps in 80 clocks at /8)
        bus_write(ra(0, 'h10), 32'h8000_0000 | 32'd1000);
        bus_read(ra(0, 'h00), rd); chk("R4 load with stop set", rd, 32'd1000);
        bus_write(ra(0, 'h10), 32'd1000);
        bus_read(ra(0, 'h00), rd); chk("R4 released value", rd, 32'd1000);
        wcyc(80);
        bus_read(ra(0, 'h00), rd); chk("R4 ten steps", rd, 32'd990);

        // R5 base write while running changes only the reload value
        bus_read(ra(0, 'h00), c0);
        bus_write(ra(0, 'h10), 32'd5);
        wcyc(78);
        bus_read(ra(0, 'h00), rd); chk("R5 running base write", rd, c0 - 32'd10);

        // R3 stop while running: loads and freezes
        bus_write(ra(0, 'h10), 32'h8000_0000 | 32'd42);
        wcyc(100);
        bus_read(ra(0, 'h00), rd); chk("R3 stop freezes count", rd, 32'd42);

        // R5 R6 period sweep over channels, bases and both prescales
        for (int m = 0; m < 3; m++) begin
            bus_write(10'h200, m == 0 ? 32'h0 : (m == 1 ? 32'h300 : 32'h100));
            div = (m == 1) ? 64 : 8;
            for (int ch = 0; ch < 4; ch++) begin
                for (int b = 0; b < 4; b++) begin
                    int base = (b == 3) ? 5 : b;
                    eff = (base < 1) ? 1 : base;
                    bus_write(ra(ch, 'h20), 32'(ch + 16'h40));
                    start_ch(ch, base);
                    wait_irq(ch, (eff + 2) * div + 8, n);
                    wait_irq(ch, (eff + 1) * div + 8, n);
                    chk(m == 1 ? "R6 period at /64" : "R5 period at /8", 32'(n), 32'(eff * div));
                    stop_ch(ch);
                end
            end
        end
        bus_write(10'h200, 32'h0);

        // R7 mask suppresses, R8 one-clock pulses after unmask
        bus_write(ra(3, 'h20), 32'h8000_0077);
        start_ch(3, 2);
        count_irq(3, 200, cnt); chk("R7 masked no request", 32'(cnt), 32'd0);
        bus_write(ra(3, 'h20), 32'h0000_0077);
        count_irq(3, 160, cnt); chk("R7 R8 unmasked requests", 32'(cnt), 32'd10);
        stop_ch(3);

        // R11 independence: ch0 base 3, ch2 base 5, ch1 stopped
        bus_write(ra(1, 'h10), 32'h8000_0033);
        bus_write(ra(0, 'h20), 32'h0);
        bus_write(ra(1, 'h20), 32'h0);
        bus_write(ra(2, 'h20), 32'h0);
        start_ch(0, 3);
        start_ch(2, 5);
        wait_irq(0, 64, n);
        fork
            count_irq(0, 480, cnt);
            count_irq(2, 480, cnt2);
            count_irq(1, 480, n);
        join
        chk("R11 channel 0 requests", 32'(cnt), 32'd20);
        chk("R11 channel 2 requests", 32'(cnt2), 32'd12);
        chk("R11 stopped channel quiet", 32'(n), 32'd0);
        bus_read(ra(1, 'h00), rd); chk("R11 stopped channel count", rd, 32'h33);
    endtask

    initial begin
        wcyc(4);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: run incomplete, actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule